// File: doc/BRIEF.md
# Dual-Mode Interface Selector

This block decides which of two serial engines owns a shared open-drain data line. Out of reset the block is in a streaming, transmit-only mode, in which a separate clock pin paces a continuous output stream. A clean high-to-low transition on the two-wire clock line moves the block, once and for good, into a bidirectional two-wire mode. Only a reset brings it back.

The block drives the line's pull-low from whichever engine the current mode selects and masks the other engine's request. In the two-wire mode the streaming clock pin is no longer treated as a clock. Its static level becomes a write-enable: high lets writes through and low makes the whole array read-only. An internal write cycle that has already started keeps the permission it began with, so it finishes even if the pin drops.

A falling edge on the two-wire clock counts only if the line was sampled high for at least `SCL_STABLE_CYCLES` system clocks just before it. Shorter high pulses are rejected as glitches. Both clock inputs are expected to be synchronized to `clk` already.

Top module: `dm_mode_select`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `bidir_mode_o` is 0 and `wr_permit_o` is 0.
- R2: If SCL is sampled high on at least `SCL_STABLE_CYCLES` consecutive rising edges of `clk` and then sampled low, `bidir_mode_o` reads 1 right after that rising edge.
- R3: An SCL fall preceded by fewer than `SCL_STABLE_CYCLES` high samples, or an SCL that is low with no high before it, leaves `bidir_mode_o` at 0.
- R4: Once `bidir_mode_o` is 1, it stays 1 whatever SCL does. Only reset returns it to 0.
- R5: Toggling VCLK never changes `bidir_mode_o`, in either mode.
- R6: With `bidir_mode_o` at 0, `sda_low_o` follows `stream_sda_low_i` and ignores `twi_sda_low_i`. With `bidir_mode_o` at 1, it follows `twi_sda_low_i` and ignores `stream_sda_low_i`. This path is combinational.
- R7: In transmit-only mode `wr_permit_o` is 0. In bidirectional mode with `wr_cycle_i` low, `wr_permit_o` equals the VCLK level (high means writes allowed, low means read-only).
- R8: While `wr_cycle_i` is high, `wr_permit_o` holds the value it had on the cycle before the write cycle began. A VCLK drop does not revoke it, and a VCLK rise does not grant it.
- R9: The mode flag is encoded as 0 for transmit-only and 1 for bidirectional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized two-wire clock level |
| vclk_i | input | 1 | Synchronized streaming clock / write-enable level |
| stream_sda_low_i | input | 1 | Pull-low request from the streaming engine |
| twi_sda_low_i | input | 1 | Pull-low request from the two-wire engine |
| wr_cycle_i | input | 1 | Internal write cycle in progress |
| bidir_mode_o | output | 1 | Mode flag: 0 transmit-only, 1 bidirectional |
| sda_low_o | output | 1 | Pull-low on the shared data line |
| wr_permit_o | output | 1 | Array write permitted |

## Verification
The bench sends a high pulse one cycle short of the filter length and then one of exactly the filter length. A filter with an off-by-one error would switch on the short pulse or miss the exact one. It holds SCL low out of reset to catch a design that treats a plain low level as an edge. After the switch it toggles SCL and VCLK to expose a mode flag that is not sticky or that listens to the streaming clock. It also drops and raises VCLK in the middle of a write cycle, which catches a permit that follows the pin live instead of holding its starting value, and it drives each engine's request alone to find an unmasked or swapped data-line path.

// File: rtl/dm_pkg.sv
package dm_pkg;

    typedef enum logic {
        MODE_STREAM  = 1'b0,
        MODE_TWOWIRE = 1'b1
    } dm_mode_e;

    typedef struct packed {
        logic stream_low;
        logic twi_low;
    } dm_sda_req_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/dm_scl_qualifier.sv
module dm_scl_qualifier #(
    parameter int unsigned STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    output logic fall_valid_o
);
    localparam int unsigned NEED = (STABLE_CYCLES < 1) ? 1 : STABLE_CYCLES;
    localparam int unsigned CW   = dm_pkg::cnt_width(NEED);
    localparam logic [CW-1:0] NEED_C = CW'(NEED);

    logic [CW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt <= '0;
        end else if (!scl_i) begin
            high_cnt <= '0;
        end else if (high_cnt != NEED_C) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    assign fall_valid_o = !scl_i && (high_cnt == NEED_C);
endmodule

// File: rtl/dm_sda_route.sv
module dm_sda_route (
    input  dm_pkg::dm_mode_e    mode_i,
    input  dm_pkg::dm_sda_req_t req_i,
    output logic                sda_low_o
);
    always_comb begin
        unique case (mode_i)
            dm_pkg::MODE_TWOWIRE: sda_low_o = req_i.twi_low;
            default:              sda_low_o = req_i.stream_low;
        endcase
    end
endmodule

// File: rtl/dm_wr_gate.sv
module dm_wr_gate (
    input  logic             clk,
    input  logic             rst,
    input  dm_pkg::dm_mode_e mode_i,
    input  logic             vclk_i,
    input  logic             wr_cycle_i,
    output logic             wr_permit_o
);
    logic live_permit;
    logic held_permit;

    assign live_permit = (mode_i == dm_pkg::MODE_TWOWIRE) && vclk_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_permit <= 1'b0;
        end else if (!wr_cycle_i) begin
            held_permit <= live_permit;
        end
    end

    assign wr_permit_o = wr_cycle_i ? held_permit : live_permit;
endmodule

// File: rtl/dm_mode_select.sv
module dm_mode_select #(
    parameter int unsigned SCL_STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic vclk_i,
    input  logic stream_sda_low_i,
    input  logic twi_sda_low_i,
    input  logic wr_cycle_i,
    output logic bidir_mode_o,
    output logic sda_low_o,
    output logic wr_permit_o
);
    import dm_pkg::*;

    dm_mode_e    mode_q;
    dm_sda_req_t sda_req;
    logic        fall_valid;

    dm_scl_qualifier #(.STABLE_CYCLES(SCL_STABLE_CYCLES)) u_qual (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_i),
        .fall_valid_o (fall_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_STREAM;
        end else if (fall_valid) begin
            mode_q <= MODE_TWOWIRE;
        end
    end

    assign sda_req.stream_low = stream_sda_low_i;
    assign sda_req.twi_low    = twi_sda_low_i;

    dm_sda_route u_route (
        .mode_i    (mode_q),
        .req_i     (sda_req),
        .sda_low_o (sda_low_o)
    );

    dm_wr_gate u_wr (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_q),
        .vclk_i      (vclk_i),
        .wr_cycle_i  (wr_cycle_i),
        .wr_permit_o (wr_permit_o)
    );

    assign bidir_mode_o = (mode_q == MODE_TWOWIRE);
endmodule

// File: rtl/dm_mode_select_chk.sv
module dm_mode_select_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic vclk_i,
    input logic stream_sda_low_i,
    input logic twi_sda_low_i,
    input logic wr_cycle_i,
    input logic bidir_mode_o,
    input logic sda_low_o,
    input logic wr_permit_o
);
    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!bidir_mode_o && !wr_permit_o));

    // R2
    p_switch_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bidir_mode_o) |-> (!$past(scl_i) && $past(scl_i, 2)));

    // R4
    p_sticky_mode_r4: assert property (@(posedge clk) disable iff (rst)
        bidir_mode_o |=> bidir_mode_o);

    // R6
    p_mask_twi_r6: assert property (@(posedge clk) disable iff (rst)
        (!bidir_mode_o && !stream_sda_low_i) |-> !sda_low_o);
    p_mask_stream_r6: assert property (@(posedge clk) disable iff (rst)
        (bidir_mode_o && !twi_sda_low_i) |-> !sda_low_o);

    // R7
    p_no_write_stream_r7: assert property (@(posedge clk) disable iff (rst)
        !bidir_mode_o |-> !wr_permit_o);
    p_protect_low_r7: assert property (@(posedge clk) disable iff (rst)
        (bidir_mode_o && !vclk_i && !wr_cycle_i) |-> !wr_permit_o);

    // R8
    p_hold_in_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_cycle_i && $past(wr_cycle_i) && !$past(rst)) |-> $stable(wr_permit_o));
endmodule

bind dm_mode_select dm_mode_select_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .scl_i            (scl_i),
    .vclk_i           (vclk_i),
    .stream_sda_low_i (stream_sda_low_i),
    .twi_sda_low_i    (twi_sda_low_i),
    .wr_cycle_i       (wr_cycle_i),
    .bidir_mode_o     (bidir_mode_o),
    .sda_low_o        (sda_low_o),
    .wr_permit_o      (wr_permit_o)
);

// File: tb/dm_mode_select_tb.sv
module dm_mode_select_tb;
    localparam int unsigned STABLE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b0;
    logic vclk = 1'b0;
    logic s_req = 1'b0;
    logic t_req = 1'b0;
    logic wr_cyc = 1'b0;
    logic bidir, sda_low, permit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dm_mode_select #(.SCL_STABLE_CYCLES(STABLE)) u_dut (
        .clk              (clk),
        .rst              (rst),
        .scl_i            (scl),
        .vclk_i           (vclk),
        .stream_sda_low_i (s_req),
        .twi_sda_low_i    (t_req),
        .wr_cycle_i       (wr_cyc),
        .bidir_mode_o     (bidir),
        .sda_low_o        (sda_low),
        .wr_permit_o      (permit)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; scl = 1'b0; vclk = 1'b0; s_req = 1'b0; t_req = 1'b0; wr_cyc = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 mode in reset", bidir, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mode after reset", bidir, 1'b0);
        check("R1 permit after reset", permit, 1'b0);
    endtask

    task automatic pulse_scl(input int n);
        @(negedge clk); scl = 1'b1;
        repeat (n) @(negedge clk);
        scl = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_stream_mode();
        repeat (3) @(negedge clk);
        check("R3 low without prior high", bidir, 1'b0);
        s_req = 1'b1; t_req = 1'b0; #1;
        check("R6 stream req routed", sda_low, 1'b1);
        s_req = 1'b0; t_req = 1'b1; #1;
        check("R6 twi req masked", sda_low, 1'b0);
        t_req = 1'b0;
        vclk = 1'b1; #1;
        check("R7 no permit in stream mode", permit, 1'b0);
        for (int i = 0; i < 6; i++) begin @(negedge clk); vclk = ~vclk; end
        @(negedge clk);
        check("R5 vclk toggles keep stream mode", bidir, 1'b0);
        check("R9 stream encoding", bidir, 1'b0);
    endtask

    task automatic t_glitch_then_switch();
        pulse_scl(STABLE - 1);
        check("R3 short high pulse rejected", bidir, 1'b0);
        pulse_scl(STABLE);
        check("R2 qualified fall switches", bidir, 1'b1);
        check("R9 two-wire encoding", bidir, 1'b1);
    endtask

    task automatic t_bidir_mode();
        s_req = 1'b1; t_req = 1'b0; #1;
        check("R6 stream req masked", sda_low, 1'b0);
        s_req = 1'b0; t_req = 1'b1; #1;
        check("R6 twi req routed", sda_low, 1'b1);
        t_req = 1'b0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); scl = ~scl; end
        for (int i = 0; i < 5; i++) begin @(negedge clk); vclk = ~vclk; end
        @(negedge clk);
        check("R4 stays bidir after scl activity", bidir, 1'b1);
        check("R5 stays bidir after vclk toggles", bidir, 1'b1);
        vclk = 1'b0; #1;
        check("R7 vclk low read-only", permit, 1'b0);
        vclk = 1'b1; #1;
        check("R7 vclk high permits", permit, 1'b1);
    endtask

    task automatic t_write_hold();
        @(negedge clk); vclk = 1'b1; wr_cyc = 1'b0;
        @(negedge clk); wr_cyc = 1'b1;
        @(negedge clk); vclk = 1'b0; #1;
        check("R8 permit held after vclk drop", permit, 1'b1);
        @(negedge clk);
        check("R8 permit still held", permit, 1'b1);
        wr_cyc = 1'b0; #1;
        check("R7 permit follows vclk after cycle", permit, 1'b0);
        @(negedge clk); wr_cyc = 1'b1;
        @(negedge clk); vclk = 1'b1; #1;
        check("R8 vclk rise does not grant", permit, 1'b0);
        @(negedge clk); wr_cyc = 1'b0; #1;
        check("R7 permit after protected cycle", permit, 1'b1);
    endtask

    initial begin
        do_reset();
        t_stream_mode();
        t_glitch_then_switch();
        t_bidir_mode();
        t_write_hold();
        do_reset();
        check("R4 reset returns to stream", bidir, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule